// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and status words of a 32-bit processor that runs in six operating modes. Sixteen logical register indices are visible at any time. Depending on the current mode, some of them land in private physical storage rather than the shared copy. The fast-interrupt mode owns seven private registers, at indices 8 to 14. The other four exception modes each own a private stack pointer (index 13) and link register (index 14).

Two read ports and one write port each take a 4-bit logical index, and the mode input picks the physical copy. Reads are combinational from storage. A write takes effect at the clock edge. The block also holds one current status word, shared by every mode, and one saved status word per exception mode. The saved status port always addresses the word that belongs to the present mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every logical register in every mode reads zero, the current status reads zero and the saved status reads zero in every mode.
- R2: Indices 0 to 7 and index 15 address one shared physical copy: a value written in any mode is read back in every mode.
- R3: Mode codes on the 3-bit mode input are 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined. Codes 6 and 7 behave exactly as user. In user mode, indices 8 to 14 address the user copies.
- R4: In fast-interrupt mode (code 1), indices 8 to 14 address storage private to that mode, distinct from the user copies.
- R5: In modes 2 to 5, indices 13 and 14 address a pair private to each mode. Indices 8 to 12 in those modes address the user copies.
- R6: A read of the physical register being written in the same cycle returns the old value; the new value appears after the clock edge. Both read ports work independently.
- R7: The current status word is a single register. A write in any mode is read back in every other mode after the clock edge.
- R8: Each of modes 1 to 5 has its own saved status word, and a write in one of these modes leaves the words of the others unchanged.
- R9: In user mode (codes 0, 6, 7) the saved status port reads zero and writes to it are ignored.
- R10: With the write enables low, no register or status word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current operating mode code |
| rda_idx | input | 4 | Read port A logical index |
| rda_data | output | 32 | Read port A data |
| rdb_idx | input | 4 | Read port B logical index |
| rdb_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Write logical index |
| wr_data | input | 32 | Write data |
| cur_we | input | 1 | Current status write enable |
| cur_wdata | input | 32 | Current status write data |
| cur_rdata | output | 32 | Current status value |
| sav_we | input | 1 | Saved status write enable (current mode) |
| sav_wdata | input | 32 | Saved status write data |
| sav_rdata | output | 32 | Saved status value for the current mode |

## Verification
A wrong index-to-storage mapping does not show up at the write. It shows up only when another mode later reads the same logical index. Such a fault lands in a neighbour's copy, so it appears as a stale or foreign value read in a different mode, one cycle or more after the write. The bench therefore writes a distinct pattern from every mode into every index and only then reads every index in all eight mode codes. Any aliasing is exposed by the identity of the pattern that comes back. Saved-status slot faults are found the same way, by reading each slot back after all the others have been written.

// File: rtl/bregs_pkg.sv
package bregs_pkg;

  typedef enum logic [2:0] {
    MD_USR = 3'd0,
    MD_FIQ = 3'd1,
    MD_IRQ = 3'd2,
    MD_SVC = 3'd3,
    MD_ABT = 3'd4,
    MD_UND = 3'd5
  } mode_e;

  localparam int LOG_N   = 16;
  localparam int IDX_W   = $clog2(LOG_N);
  localparam int FAST_LO = 8;
  localparam int FAST_HI = 14;
  localparam int FAST_N  = FAST_HI - FAST_LO + 1;
  localparam int PAIR_N  = 4;
  localparam int PHYS_N  = LOG_N + FAST_N + 2 * PAIR_N;
  localparam int PHYS_W  = $clog2(PHYS_N);
  localparam int FAST_BASE = LOG_N;
  localparam int PAIR_BASE = LOG_N + FAST_N;
  localparam int SLOT_N  = 5;
  localparam int SLOT_W  = $clog2(SLOT_N);

  // Logical index plus mode to physical slot
  function automatic logic [PHYS_W-1:0] phys_of(input logic [2:0] md,
                                                input logic [IDX_W-1:0] idx);
    logic [PHYS_W-1:0] p;
    p = PHYS_W'(idx);
    if (md == MD_FIQ && idx >= IDX_W'(FAST_LO) && idx <= IDX_W'(FAST_HI))
      p = PHYS_W'(FAST_BASE) + PHYS_W'(idx - IDX_W'(FAST_LO));
    else if (md >= MD_IRQ && md <= MD_UND && (idx == 4'd13 || idx == 4'd14))
      p = PHYS_W'(PAIR_BASE) + PHYS_W'({md - 3'd2, 1'b0}) + PHYS_W'(idx - 4'd13);
    return p;
  endfunction

endpackage

// File: rtl/breg_rst_sync.sv
module breg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/breg_bank_map.sv
module breg_bank_map
  import bregs_pkg::*;
(
  input  logic [2:0]        mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  always_comb phys = phys_of(mode, idx);
endmodule

// File: rtl/breg_status.sv
module breg_status
  import bregs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic [2:0]    mode,
  input  logic          cur_we,
  input  logic [DW-1:0] cur_wdata,
  output logic [DW-1:0] cur_rdata,
  input  logic          sav_we,
  input  logic [DW-1:0] sav_wdata,
  output logic [DW-1:0] sav_rdata
);
  logic [DW-1:0]             cur_q, cur_d;
  logic [SLOT_N-1:0][DW-1:0] sav_q;
  logic [SLOT_N-1:0]         sav_en;
  logic                      slot_ok;
  logic [SLOT_W-1:0]         slot;

  always_comb begin
    slot_ok = (mode >= MD_FIQ) && (mode <= MD_UND);
    slot    = slot_ok ? SLOT_W'(mode - 3'd1) : '0;
    cur_d   = cur_we ? cur_wdata : cur_q;
  end

  for (genvar k = 0; k < SLOT_N; k++) begin : g_slot_en
    assign sav_en[k] = sav_we && slot_ok && (slot == SLOT_W'(k));
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cur_q <= '0;
      sav_q <= '0;
    end else begin
      cur_q <= cur_d;
      for (int k = 0; k < SLOT_N; k++)
        if (sav_en[k]) sav_q[k] <= sav_wdata;
    end
  end

  assign cur_rdata = cur_q;
  assign sav_rdata = slot_ok ? sav_q[slot] : '0;

  // R7
  cur_wr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(cur_we && rst_ns) |-> cur_rdata == $past(cur_wdata));

  // R9
  sav_user_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (sav_we && !(mode inside {[3'd1:3'd5]})) |=> $stable(sav_q));

  // R10
  sav_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !sav_we |=> $stable(sav_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bregs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [3:0]    rda_idx,
  output logic [DW-1:0] rda_data,
  input  logic [3:0]    rdb_idx,
  output logic [DW-1:0] rdb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          cur_we,
  input  logic [DW-1:0] cur_wdata,
  output logic [DW-1:0] cur_rdata,
  input  logic          sav_we,
  input  logic [DW-1:0] sav_wdata,
  output logic [DW-1:0] sav_rdata
);
  localparam int PORT_N = 3;

  logic                      rst_ns;
  logic                      wr_go;
  logic [PORT_N-1:0][IDX_W-1:0]  map_idx;
  logic [PORT_N-1:0][PHYS_W-1:0] map_phys;
  logic [PHYS_N-1:0][DW-1:0] reg_q;
  logic [PHYS_N-1:0]         reg_en;

  breg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  assign wr_go   = wr_en && rst_ns;
  assign map_idx = {wr_idx, rdb_idx, rda_idx};

  for (genvar p = 0; p < PORT_N; p++) begin : g_map
    breg_bank_map u_map (.mode(mode), .idx(map_idx[p]), .phys(map_phys[p]));
  end

  for (genvar k = 0; k < PHYS_N; k++) begin : g_wen
    assign reg_en[k] = wr_go && (map_phys[2] == PHYS_W'(k));
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      reg_q <= '0;
    end else begin
      for (int k = 0; k < PHYS_N; k++)
        if (reg_en[k]) reg_q[k] <= wr_data;
    end
  end

  assign rda_data = reg_q[map_phys[0]];
  assign rdb_data = reg_q[map_phys[1]];

  breg_status #(.DW(DW)) u_sts (
    .clk(clk), .rst_ns(rst_ns), .mode(mode),
    .cur_we(cur_we && rst_ns), .cur_wdata(cur_wdata), .cur_rdata(cur_rdata),
    .sav_we(sav_we && rst_ns), .sav_wdata(sav_wdata), .sav_rdata(sav_rdata)
  );

  // R6
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(wr_go) && mode == $past(mode) && rda_idx == $past(wr_idx))
      |-> rda_data == $past(wr_data));

  // R2
  shared_low_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(wr_go) && ($past(wr_idx) < 4'd8 || $past(wr_idx) == 4'd15)
      && rdb_idx == $past(wr_idx)) |-> rdb_data == $past(wr_data));

  // R4
  fast_private_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode == MD_FIQ && wr_idx >= 4'd8 && wr_idx <= 4'd14)
      |-> map_phys[2] >= PHYS_W'(FAST_BASE));

  // R9
  sav_user_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode == MD_USR || mode > MD_UND) |-> sav_rdata == '0);
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/100ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic [3:0]  rda_idx, rdb_idx, wr_idx;
  logic [31:0] rda_data, rdb_data, wr_data;
  logic        wr_en, cur_we, sav_we;
  logic [31:0] cur_wdata, cur_rdata, sav_wdata, sav_rdata;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rda_idx(rda_idx), .rda_data(rda_data),
    .rdb_idx(rdb_idx), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_rdata(cur_rdata),
    .sav_we(sav_we), .sav_wdata(sav_wdata), .sav_rdata(sav_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int m, input int i);
    return 32'hA000_0000 | (m << 8) | i;
  endfunction

  // Which mode's write a read of (mode r, index i) sees after the sweep
  function automatic int owner(input int r, input int i);
    if (i < 8 || i == 15) return 5;
    if (r == 1) return 1;
    if (i <= 12) return 5;
    if (r >= 2 && r <= 5) return r;
    return 0;
  endfunction

  task automatic write_reg(input int m, input int i, input logic [31:0] d);
    @(negedge clk);
    mode = 3'(m); wr_idx = 4'(i); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_pair(input int m, input int i, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    mode = 3'(m); rda_idx = 4'(i); rdb_idx = 4'(i);
    #1;
    a = rda_data; b = rdb_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    rst_n = 1'b0; mode = 3'd0; rda_idx = '0; rdb_idx = '0; wr_idx = '0;
    wr_en = 1'b0; wr_data = '0; cur_we = 1'b0; cur_wdata = '0;
    sav_we = 1'b0; sav_wdata = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state everywhere
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 16; i++) begin
        read_pair(m, i, a, b);
        check("R1 reg A", a, 32'h0);
        check("R1 reg B", b, 32'h0);
      end
      check("R1 saved", sav_rdata, 32'h0);
      check("R1 current", cur_rdata, 32'h0);
    end

    // R2 R3 R4 R5: write every index in modes 0..5, then read in all codes
    for (int m = 0; m < 6; m++)
      for (int i = 0; i < 16; i++)
        write_reg(m, i, pat(m, i));
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 16; i++) begin
        read_pair(m, i, a, b);
        if (i < 8 || i == 15)      check("R2 shared", a, pat(owner(m, i), i));
        else if (m == 1)           check("R4 fast private", a, pat(owner(m, i), i));
        else if (m >= 2 && m <= 5) check("R5 pair banking", a, pat(owner(m, i), i));
        else                       check("R3 user view", a, pat(owner(m, i), i));
        check("R6 port B", b, pat(owner(m, i), i));
      end

    // R6: same-cycle read returns old value, new after edge
    @(negedge clk);
    mode = 3'd1; rda_idx = 4'd9; rdb_idx = 4'd2;
    wr_idx = 4'd9; wr_data = 32'h1234_5678; wr_en = 1'b1;
    #1;
    check("R6 old value", rda_data, pat(1, 9));
    check("R6 other port", rdb_data, pat(5, 2));
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R6 new value", rda_data, 32'h1234_5678);
    read_pair(0, 9, a, b);
    check("R4 user copy untouched", a, pat(5, 9));

    // R10: disabled write leaves storage unchanged
    @(negedge clk);
    mode = 3'd3; wr_idx = 4'd13; wr_data = 32'hFFFF_FFFF; wr_en = 1'b0;
    @(negedge clk);
    read_pair(3, 13, a, b);
    check("R10 no write", a, pat(3, 13));

    // R7: current status shared across modes
    @(negedge clk);
    mode = 3'd2; cur_wdata = 32'hC0DE_0042; cur_we = 1'b1;
    @(negedge clk);
    cur_we = 1'b0; mode = 3'd4;
    #1;
    check("R7 current shared", cur_rdata, 32'hC0DE_0042);

    // R8: per-mode saved status words
    for (int m = 1; m < 6; m++) begin
      @(negedge clk);
      mode = 3'(m); sav_wdata = 32'h5000_0000 | m; sav_we = 1'b1;
      @(negedge clk);
      sav_we = 1'b0;
    end
    // R9: user-mode writes ignored, reads zero
    for (int m = 0; m < 8; m++) begin
      if (m >= 1 && m <= 5) continue;
      @(negedge clk);
      mode = 3'(m); sav_wdata = 32'hDEAD_BEEF; sav_we = 1'b1;
      #1;
      check("R9 user read zero", sav_rdata, 32'h0);
      @(negedge clk);
      sav_we = 1'b0;
    end
    for (int m = 1; m < 6; m++) begin
      @(negedge clk);
      mode = 3'(m);
      #1;
      check("R8 saved slot", sav_rdata, 32'h5000_0000 | m);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule